// File: doc/BRIEF.md
# Priority Address Region Attribute Matcher

The block resolves the memory attributes that apply to a 32-bit physical address. Eight programmable regions are presented to it as flat vectors from a configuration register bank. Each region carries a base address, a four-bit logarithmic size code and an attribute byte. For every valid lookup the block registers a hit flag, the index of the winning region and three attribute flags: cacheable, write gathering and weak write ordering.

Regions 0 to 6 describe exceptions such as frame buffers or legacy holes, and in them an attribute bit marks the region as uncached. Region 7 is the background region that normally covers main memory. In region 7 the same bit has the opposite meaning and marks the region as cached. Region 7 is used only when none of the other regions claims the address. An address that no region claims is treated as uncached, with every flag cleared.

Top module: `regionAttrMatcher`

## Requirements
- R1: A region whose size code is 0 never matches, whatever its base address.
- R2: A nonzero size code n gives a region of 4 KB × 2^(n−1) bytes (code 6 = 128 KB, code 9 = 1 MB, code 10 = 2 MB, code 11 = 4 MB). The region matches when the address bits at and above position 11+n equal the same bits of the base, so the first address past the end of the region misses.
- R3: Each region occupies 24 bits of `regionCfg`, with region i at bits [24i+23:24i]. Bits [7:0] of the slice hold base address bits 31:24, bits [15:8] hold base bits 23:16, bits [23:20] hold base bits 15:12 and bits [19:16] hold the size code.
- R4: For regions 0 to 6, attribute bit 0 set means not cached and clear means cached.
- R5: For region 7, attribute bit 0 set means cached and clear means not cached.
- R6: In every region, attribute bit 3 sets the write-gathering flag and attribute bit 1 sets the weak-ordering flag. Region i's attribute byte is `regionAttr[8i+7:8i]`.
- R7: When several of regions 0 to 6 match, the lowest-numbered one supplies the index and the flags.
- R8: Region 7 wins only when none of regions 0 to 6 matches, even if it overlaps them.
- R9: When no region matches, the hit flag, the index and all three attribute flags are 0.
- R10: `resultValid` rises exactly one cycle after `lookupValid` is sampled high, and the result outputs then hold their values until the next valid lookup.
- R11: During and after reset, all outputs are 0 until the first lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupAddr | input | 32 | Physical address to classify |
| regionCfg | input | 192 | Base and size code of the eight regions, 24 bits each |
| regionAttr | input | 64 | Attribute bytes of the eight regions |
| resultValid | output | 1 | Result registered from the previous cycle's lookup |
| regionHit | output | 1 | Some region matched |
| regionIndex | output | 3 | Winning region, 0 on a miss |
| cacheable | output | 1 | Address is cacheable |
| writeGather | output | 1 | Write gathering allowed |
| weakOrder | output | 1 | Weak write ordering allowed |

## Verification
The hardest cases to reach from the ports are an address that lies inside several regions at once, and an address that sits exactly on a region's last byte or on the first byte past it. Random region maps with independent bases would almost never produce these. The stimulus therefore derives each address from the base and size of a region picked at random, so the address often lands inside it, and it also uses a fixed overlapping map with lookups placed at the region edges. This exercises the lowest-index rule and the fallback to the background region.

// File: rtl/regionAttrPkg.sv
package regionAttrPkg;

  localparam int NUM_REGIONS  = 8;
  localparam int REGION_IDX_W = $clog2(NUM_REGIONS);
  localparam int ADDR_W       = 32;
  localparam int PAGE_SHIFT   = 12;
  localparam int CFG_W        = 24;
  localparam int ATTR_W       = 8;
  localparam int SIZE_W       = 4;

  // attribute bit positions
  localparam int ATTR_CACHE_BIT  = 0;
  localparam int ATTR_WEAK_BIT   = 1;
  localparam int ATTR_GATHER_BIT = 3;

  // strobes from the selection control to the datapath
  typedef struct packed {
    logic                    loadEn;
    logic                    hit;
    logic                    useLast;
    logic [REGION_IDX_W-1:0] winIdx;
  } ctrlStrobeT;

endpackage

// File: rtl/regionCompare.sv
module regionCompare #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SIZE_W-1:0] sizeCode,
  output logic              match
);

  logic [ADDR_W-1:0] keepMask;
  logic              enabled;
  int                lowBit;

  always_comb begin
    enabled = (sizeCode != '0);
    lowBit  = PAGE_SHIFT - 1 + int'(sizeCode);
    for (int b = 0; b < ADDR_W; b++) begin
      keepMask[b] = (b >= lowBit);
    end
    match = enabled && (((addr ^ base) & keepMask) == '0);
  end

  // R1: a region with size code zero never claims an address
  assert_disabled_nomatch_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCode == '0) |-> !match);

  // R2: a match always agrees with the base above the largest possible region
  assert_top_bits_agree_R2: assert property (@(posedge clk) disable iff (!rstN)
    match |-> (addr[ADDR_W-1] == base[ADDR_W-1]));

endmodule

// File: rtl/regionSelectCtrl.sv
module regionSelectCtrl
  import regionAttrPkg::*;
#(
  parameter int NREG  = NUM_REGIONS,
  parameter int IDX_W = REGION_IDX_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic [NREG-1:0] matchVec,
  output ctrlStrobeT      strobes,
  output logic            resultValid
);

  localparam int LAST = NREG - 1;

  logic             lowHit;
  logic [IDX_W-1:0] lowIdx;

  // lowest-numbered match among the ordinary regions
  always_comb begin
    lowHit = 1'b0;
    lowIdx = '0;
    for (int i = LAST - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        lowHit = 1'b1;
        lowIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobes.loadEn  = lookupValid;
    strobes.useLast = !lowHit && matchVec[LAST];
    strobes.hit     = lowHit || matchVec[LAST];
    if (lowHit)               strobes.winIdx = lowIdx;
    else if (matchVec[LAST])  strobes.winIdx = IDX_W'(LAST);
    else                      strobes.winIdx = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= lookupValid;
  end

  // R10: one-cycle latency from request to result
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> resultValid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !resultValid);

  // R7: the chosen ordinary region really matched
  assert_winner_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hit && !strobes.useLast) |-> matchVec[strobes.winIdx]);

  // R8: the background region is chosen only when it stands alone
  assert_last_alone_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useLast |-> (matchVec[LAST - 1:0] == '0));

endmodule

// File: rtl/regionMatchDp.sv
module regionMatchDp
  import regionAttrPkg::*;
#(
  parameter int NREG   = NUM_REGIONS,
  parameter int IDX_W  = REGION_IDX_W,
  parameter int AW     = ADDR_W,
  parameter int PSHIFT = PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [AW-1:0]      lookupAddr,
  input  logic [NREG*CFG_W-1:0]  regionCfg,
  input  logic [NREG*ATTR_W-1:0] regionAttr,
  input  ctrlStrobeT         strobes,
  output logic [NREG-1:0]    matchVec,
  output logic               hitQ,
  output logic [IDX_W-1:0]   idxQ,
  output logic               cacheQ,
  output logic               gatherQ,
  output logic               weakQ
);

  for (genvar g = 0; g < NREG; g++) begin : genRegion
    logic [CFG_W-1:0]  slice;
    logic [AW-1:0]     baseAddr;
    logic [SIZE_W-1:0] sizeCode;

    assign slice    = regionCfg[g*CFG_W +: CFG_W];
    assign baseAddr = {slice[7:0], slice[15:8], slice[23:20], {PSHIFT{1'b0}}};
    assign sizeCode = slice[19:16];

    regionCompare #(
      .ADDR_W    (AW),
      .PAGE_SHIFT(PSHIFT),
      .SIZE_W    (SIZE_W)
    ) i_regionCompare (
      .clk     (clk),
      .rstN    (rstN),
      .addr    (lookupAddr),
      .base    (baseAddr),
      .sizeCode(sizeCode),
      .match   (matchVec[g])
    );
  end

  logic [ATTR_W-1:0] attrSel;
  logic              cacheNext;
  logic              gatherNext;
  logic              weakNext;
  logic              unusedAttrBits;

  always_comb begin
    attrSel    = regionAttr[strobes.winIdx*ATTR_W +: ATTR_W];
    // the background region inverts the sense of the cache bit
    cacheNext  = strobes.hit && (strobes.useLast ? attrSel[ATTR_CACHE_BIT]
                                                 : !attrSel[ATTR_CACHE_BIT]);
    gatherNext = strobes.hit && attrSel[ATTR_GATHER_BIT];
    weakNext   = strobes.hit && attrSel[ATTR_WEAK_BIT];
  end

  assign unusedAttrBits = ^{attrSel[7:4], attrSel[2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ    <= 1'b0;
      idxQ    <= '0;
      cacheQ  <= 1'b0;
      gatherQ <= 1'b0;
      weakQ   <= 1'b0;
    end else if (strobes.loadEn) begin
      hitQ    <= strobes.hit;
      idxQ    <= strobes.winIdx;
      cacheQ  <= cacheNext;
      gatherQ <= gatherNext;
      weakQ   <= weakNext;
    end
  end

  // R9: a miss carries no attributes and index zero
  assert_miss_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (!cacheQ && !gatherQ && !weakQ && idxQ == '0));

  // R10: results hold while no lookup is requested
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> ($stable(hitQ) && $stable(idxQ) && $stable(cacheQ)));

endmodule

// File: rtl/regionAttrMatcher.sv
module regionAttrMatcher
  import regionAttrPkg::*;
#(
  parameter int NREG   = NUM_REGIONS,
  parameter int AW     = ADDR_W,
  parameter int PSHIFT = PAGE_SHIFT,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [AW-1:0]          lookupAddr,
  input  logic [NREG*CFG_W-1:0]  regionCfg,
  input  logic [NREG*ATTR_W-1:0] regionAttr,
  output logic                   resultValid,
  output logic                   regionHit,
  output logic [IDX_W-1:0]       regionIndex,
  output logic                   cacheable,
  output logic                   writeGather,
  output logic                   weakOrder
);

  ctrlStrobeT      strobes;
  logic [NREG-1:0] matchVec;

  regionSelectCtrl #(
    .NREG (NREG),
    .IDX_W(IDX_W)
  ) i_regionSelectCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .lookupValid(lookupValid),
    .matchVec   (matchVec),
    .strobes    (strobes),
    .resultValid(resultValid)
  );

  regionMatchDp #(
    .NREG  (NREG),
    .IDX_W (IDX_W),
    .AW    (AW),
    .PSHIFT(PSHIFT)
  ) i_regionMatchDp (
    .clk       (clk),
    .rstN      (rstN),
    .lookupAddr(lookupAddr),
    .regionCfg (regionCfg),
    .regionAttr(regionAttr),
    .strobes   (strobes),
    .matchVec  (matchVec),
    .hitQ      (regionHit),
    .idxQ      (regionIndex),
    .cacheQ    (cacheable),
    .gatherQ   (writeGather),
    .weakQ     (weakOrder)
  );

endmodule

// File: tb/test_regionAttrMatcher.sv
`timescale 1ns/1ps
module test_regionAttrMatcher;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lookupValid = 1'b0;
  logic [31:0]  lookupAddr = '0;
  logic [191:0] regionCfg = '0;
  logic [63:0]  regionAttr = '0;
  logic         resultValid, regionHit, cacheable, writeGather, weakOrder;
  logic [2:0]   regionIndex;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regionAttrMatcher i_regionAttrMatcher (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .regionCfg(regionCfg), .regionAttr(regionAttr), .resultValid(resultValid),
    .regionHit(regionHit), .regionIndex(regionIndex), .cacheable(cacheable),
    .writeGather(writeGather), .weakOrder(weakOrder)
  );

  function automatic logic [6:0] observed();
    return {regionHit, regionIndex, cacheable, writeGather, weakOrder};
  endfunction

  function automatic int regShift(input int i);
    return 11 + int'(regionCfg[i*24+16 +: 4]);
  endfunction

  function automatic logic [31:0] regBase(input int i);
    logic [23:0] s = regionCfg[i*24 +: 24];
    return {s[7:0], s[15:8], s[23:20], 12'h000};
  endfunction

  function automatic bit regHits(input int i, input logic [31:0] a);
    if (regionCfg[i*24+16 +: 4] == 4'd0) return 0;
    return (a >> regShift(i)) == (regBase(i) >> regShift(i));
  endfunction

  // expected {hit, index, cacheable, gather, weak}
  function automatic logic [6:0] model(input logic [31:0] a);
    logic [7:0] at;
    for (int i = 0; i < 7; i++) begin
      if (regHits(i, a)) begin
        at = regionAttr[i*8 +: 8];
        return {1'b1, 3'(i), ~at[0], at[3], at[1]};
      end
    end
    if (regHits(7, a)) begin
      at = regionAttr[56 +: 8];
      return {1'b1, 3'd7, at[0], at[3], at[1]};
    end
    return 7'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setRegion(input int i, input logic [31:0] base, input logic [3:0] code, input logic [7:0] attr);
    regionCfg[i*24 +: 24] = {base[15:12], code, base[23:16], base[31:24]};
    regionAttr[i*8 +: 8]  = attr;
  endtask

  task automatic lookup(input logic [31:0] a, input string tag, input bit holdCheck);
    logic [6:0] exp;
    @(negedge clk);
    lookupValid = 1'b1;
    lookupAddr  = a;
    exp = model(a);
    @(negedge clk);
    lookupValid = 1'b0;
    lookupAddr  = ~a;
    check(resultValid == 1'b1, "R10 valid latency", 32'(resultValid), 32'd1);
    check(observed() == exp, tag, 32'(observed()), 32'(exp));
    if (holdCheck) begin
      @(negedge clk);
      check(resultValid == 1'b0 && observed() == exp, "R10 hold",
            32'({resultValid, observed()}), 32'(exp));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int r;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    check({resultValid, observed()} == 8'd0, "R11 reset", 32'({resultValid, observed()}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({resultValid, observed()} == 8'd0, "R11 after reset", 32'({resultValid, observed()}), 32'd0);

    // R1: bases cover the address but every size code is zero
    for (int i = 0; i < 8; i++) setRegion(i, 32'h0000_0000, 4'd0, 8'h0B);
    lookup(32'h0000_1234, "R1 disabled regions miss", 1);
    lookup(32'h0000_0000, "R9 all-zero miss", 0);

    // overlapping map with a background region
    for (int i = 0; i < 8; i++) setRegion(i, 32'h0, 4'd0, 8'h00);
    setRegion(0, 32'h000A_0000, 4'd6,  8'h09);
    setRegion(1, 32'h000C_0000, 4'd7,  8'h01);
    setRegion(3, 32'h000A_8000, 4'd4,  8'h09);
    setRegion(6, 32'hE000_0000, 4'd10, 8'h09);
    setRegion(7, 32'h0000_0000, 4'd14, 8'h0B);
    lookup(32'h000A_8100, "R7 lowest index wins overlap", 1);
    lookup(32'hE01F_FFFF, "R2 R3 last byte of 2MB region", 0);
    lookup(32'hE020_0000, "R2 R9 first byte past region", 0);
    lookup(32'hE000_0000, "R3 base byte placement", 0);
    lookup(32'h0010_0000, "R5 R8 background cached", 1);
    lookup(32'h000F_FFFF, "R4 region 1 uncached", 0);
    lookup(32'h000B_FFFF, "R8 ordinary beats background", 0);
    lookup(32'h01FF_FFFF, "R2 background last byte", 0);
    lookup(32'h0200_0000, "R9 miss past background", 0);

    // R4 with cache bit clear, R6 weak ordering alone
    setRegion(2, 32'h4000_0000, 4'd1, 8'h02);
    lookup(32'h4000_0FFF, "R4 R6 cached weak 4KB", 0);
    lookup(32'h4000_1000, "R2 4KB boundary miss", 0);
    // R5 background with cache bit clear
    setRegion(7, 32'h0000_0000, 4'd14, 8'h08);
    lookup(32'h0000_0100, "R5 background uncached", 1);
    // R6 attribute upper bits ignored
    setRegion(5, 32'h8000_0000, 4'd15, 8'hF4);
    lookup(32'h83FF_FFFF, "R6 ignored bits", 0);

    // constrained random maps
    for (int m = 0; m < 400; m++) begin
      for (int i = 0; i < 8; i++)
        setRegion(i, $urandom(), 4'($urandom_range(0, 15)), 8'($urandom()));
      if ($urandom_range(0, 3) != 0) setRegion(7, 32'h0, 4'($urandom_range(12, 15)), 8'($urandom()));
      for (int k = 0; k < 8; k++) begin
        r = $urandom_range(0, 8);
        if (r == 8 || regionCfg[r*24+16 +: 4] == 4'd0) a = $urandom();
        else a = regBase(r) ^ ($urandom() & ((32'd1 << regShift(r)) - 32'd1));
        if ($urandom_range(0, 5) == 0) a = a ^ (32'd1 << ($urandom_range(12, 26)));
        lookup(a, "R7 R8 R2 random map", 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule